// File: doc/BRIEF.md
# Polarity-Aware GPIO Level Register

This block holds the level bits for nine general-purpose pins behind a simple register bus. A per-channel configuration, supplied from elsewhere as a 4-bit function code, a direction bit and a polarity bit, decides what each pin does. A channel in plain GPIO function (code 0) with direction 0 is an output: its stored level drives the pad and its output enable is raised. Every other channel leaves the pad undriven, and its level bit only reflects the pin.

Software writes the level word to set output values and reads it to sample pin levels. The polarity bit sits on both paths. With polarity 1 the register value matches the pin. With polarity 0 the register holds the inverse of the pin, both for the level that is driven and for the level that is sampled. Pad inputs pass through a two-flop synchronizer before the polarity is applied. A read therefore always returns the synchronized pin, including on output channels.

Top module: `gpio_level_reg`

## Requirements
- R1: Channel n (n = 1..9) maps to bit n-1 of the level word. Channel 1 is bit 0 and channel 9 is bit 8. Index k of every per-channel port is channel k+1.
- R2: After reset every stored level bit is 0. With polarity 1 the pad output is 0; with polarity 0 it is 1.
- R3: padOe of a channel is 1 exactly when its function code is 0 and its direction bit is 0. A write updates the stored level of such a channel on the next clock edge.
- R4: A write leaves the stored level of a channel that is not an output unchanged. Output channels covered by the same write still update.
- R5: padOut of a channel equals the stored level when its polarity is 1 and the inverse of the stored level when its polarity is 0.
- R6: The read value of a channel equals the synchronized pad level when its polarity is 1 and its inverse when its polarity is 0.
- R7: A change on padIn appears in the read data after two rising clock edges. The synchronizer flops reset to 0.
- R8: Read data bits 15 to 9 are always 0. Written bits 15 to 9 change nothing.
- R9: The level word sits at address 0x400C. A read of any other address returns 0, and a write to any other address changes no stored level.
- R10: On an output channel a read returns the synchronized pad level, not the stored level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | 16 | Register address |
| busWrEn | input | 1 | Write strobe, sampled on the rising edge |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Combinational read data |
| cfgFunc | input | 36 | 4-bit function code per channel, channel k+1 at bits 4k+3..4k |
| cfgDir | input | 9 | Direction per channel, 0 = output |
| cfgPol | input | 9 | Polarity per channel, 1 = non-inverted |
| padIn | input | 9 | Asynchronous pad input levels |
| padOut | output | 9 | Pad drive levels |
| padOe | output | 9 | Pad output enables |

## Verification
The bound assertions check the following on every cycle: the output-enable rule, the zero upper read bits, the zero read of foreign addresses, the polarity-adjusted drive after an eligible write, the hold of padOut on channels that were not written, and the two-edge sample delay through the synchronizer. Only the bench scenarios can show some behaviours: the reset values, the bit-to-channel mapping, and that a blocked write is really dropped rather than deferred (it becomes visible once the channel is turned into an output). The same holds for a read on an output channel that returns the looped-back pin and not the written value.

// File: rtl/gpio_level_pkg.sv
package gpio_level_pkg;
  // Strobes from address decode to the level datapath
  typedef struct packed {
    logic levelSel;    // bus address hits the level word
    logic levelWrite;  // write strobe qualified by the address hit
  } levelStrobe_t;
endpackage

// File: rtl/gpio_level_ctrl.sv
module gpio_level_ctrl
  import gpio_level_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] LEVEL_ADDR = 16'h400C
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output levelStrobe_t      strobe
);
  always_comb begin
    strobe.levelSel   = (busAddr == LEVEL_ADDR);
    strobe.levelWrite = strobe.levelSel && busWrEn;
  end
endmodule

// File: rtl/gpio_level_dp.sv
module gpio_level_dp
  import gpio_level_pkg::*;
#(
  parameter int NUM_CH = 9,
  parameter int FN_W   = 4,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  levelStrobe_t           strobe,
  input  logic [NUM_CH-1:0]      wrData,
  input  logic [NUM_CH*FN_W-1:0] cfgFunc,
  input  logic [NUM_CH-1:0]      cfgDir,
  input  logic [NUM_CH-1:0]      cfgPol,
  input  logic [NUM_CH-1:0]      padIn,
  output logic [NUM_CH-1:0]      padOut,
  output logic [NUM_CH-1:0]      padOe,
  output logic [DATA_W-1:0]      rdData
);
  localparam int PAD_W = DATA_W - NUM_CH;

  logic [NUM_CH-1:0] storedLvl;
  logic [NUM_CH-1:0] syncFirst;
  logic [NUM_CH-1:0] syncSecond;
  logic [NUM_CH-1:0] sampledLvl;
  logic [NUM_CH-1:0] isOutput;

  // Two-flop synchronizer, applied ahead of the polarity
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncFirst  <= '0;
      syncSecond <= '0;
    end else begin
      syncFirst  <= padIn;
      syncSecond <= syncFirst;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    assign isOutput[ch] = (cfgFunc[ch*FN_W +: FN_W] == '0) && !cfgDir[ch];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        storedLvl[ch] <= 1'b0;
      else if (strobe.levelWrite && isOutput[ch])
        storedLvl[ch] <= wrData[ch];
    end

    assign padOut[ch]     = cfgPol[ch] ? storedLvl[ch] : ~storedLvl[ch];
    assign sampledLvl[ch] = cfgPol[ch] ? syncSecond[ch] : ~syncSecond[ch];
  end

  assign padOe  = isOutput;
  assign rdData = strobe.levelSel ? {{PAD_W{1'b0}}, sampledLvl} : '0;
endmodule

// File: rtl/gpio_level_reg.sv
module gpio_level_reg
  import gpio_level_pkg::*;
#(
  parameter int NUM_CH = 9,
  parameter int FN_W   = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] LEVEL_ADDR = 16'h400C
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic                   busWrEn,
  input  logic [DATA_W-1:0]      busWrData,
  output logic [DATA_W-1:0]      busRdData,
  input  logic [NUM_CH*FN_W-1:0] cfgFunc,
  input  logic [NUM_CH-1:0]      cfgDir,
  input  logic [NUM_CH-1:0]      cfgPol,
  input  logic [NUM_CH-1:0]      padIn,
  output logic [NUM_CH-1:0]      padOut,
  output logic [NUM_CH-1:0]      padOe
);
  levelStrobe_t strobe;
  logic         unusedWrHigh;

  assign unusedWrHigh = ^busWrData[DATA_W-1:NUM_CH];

  gpio_level_ctrl #(
    .ADDR_W    (ADDR_W),
    .LEVEL_ADDR(LEVEL_ADDR)
  ) u_ctrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .strobe (strobe)
  );

  gpio_level_dp #(
    .NUM_CH(NUM_CH),
    .FN_W  (FN_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .wrData (busWrData[NUM_CH-1:0]),
    .cfgFunc(cfgFunc),
    .cfgDir (cfgDir),
    .cfgPol (cfgPol),
    .padIn  (padIn),
    .padOut (padOut),
    .padOe  (padOe),
    .rdData (busRdData)
  );
endmodule

// File: rtl/gpio_level_chk.sv
module gpio_level_chk #(
  parameter int NUM_CH = 9,
  parameter int FN_W   = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] LEVEL_ADDR = 16'h400C
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ADDR_W-1:0]      busAddr,
  input logic                   busWrEn,
  input logic [DATA_W-1:0]      busWrData,
  input logic [DATA_W-1:0]      busRdData,
  input logic [NUM_CH*FN_W-1:0] cfgFunc,
  input logic [NUM_CH-1:0]      cfgDir,
  input logic [NUM_CH-1:0]      cfgPol,
  input logic [NUM_CH-1:0]      padIn,
  input logic [NUM_CH-1:0]      padOut,
  input logic [NUM_CH-1:0]      padOe
);
  // Cycles since reset, saturating, guards the two-deep $past
  logic [1:0] upCnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  assert_foreign_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busAddr != LEVEL_ADDR) |-> (busRdData == '0));

  assert_upper_bits_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busRdData[DATA_W-1:NUM_CH] == '0);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    assert_oe_rule_R3: assert property (@(posedge clk) disable iff (!rst_n)
      padOe[ch] == ((cfgFunc[ch*FN_W +: FN_W] == '0) && !cfgDir[ch]));

    assert_drive_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busWrEn && busAddr == LEVEL_ADDR && padOe[ch]) |=>
        (!$stable(cfgPol[ch]) ||
         padOut[ch] == ($past(cfgPol[ch]) ? $past(busWrData[ch]) : !$past(busWrData[ch]))));

    assert_hold_unwritten_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(busWrEn && busAddr == LEVEL_ADDR && padOe[ch]) |=>
        (!$stable(cfgPol[ch]) || $stable(padOut[ch])));

    assert_sample_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (upCnt >= 2'd2 && busAddr == LEVEL_ADDR) |->
        busRdData[ch] == (cfgPol[ch] ? $past(padIn[ch], 2) : !$past(padIn[ch], 2)));
  end
endmodule

bind gpio_level_reg gpio_level_chk #(
  .NUM_CH(NUM_CH), .FN_W(FN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEVEL_ADDR(LEVEL_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .busRdData(busRdData), .cfgFunc(cfgFunc),
  .cfgDir(cfgDir), .cfgPol(cfgPol), .padIn(padIn), .padOut(padOut), .padOe(padOe)
);

// File: tb/gpio_level_reg_tb.sv
module gpio_level_reg_tb;
  localparam int NCH = 9;
  localparam logic [15:0] LVL = 16'h400C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] busAddr = LVL;
  logic        busWrEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic [35:0] cfgFunc = '0;
  logic [8:0]  cfgDir = '0;
  logic [8:0]  cfgPol = '1;
  logic [8:0]  padIn = '0;
  logic [8:0]  padOut;
  logic [8:0]  padOe;

  int vectors = 0;
  int misses = 0;

  // Behavioural reference state
  bit   mStored[NCH];
  logic [8:0] padHist[$];

  always #5 clk = ~clk;

  gpio_level_reg u_dut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .cfgFunc(cfgFunc),
    .cfgDir(cfgDir), .cfgPol(cfgPol), .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  function automatic bit chanIsOut(int k);
    return (((cfgFunc >> (4*k)) & 36'hF) == 0) && (cfgDir[k] == 1'b0);
  endfunction

  task automatic check(string tag);
    logic [8:0]  eOut, eOe;
    logic [15:0] eRd;
    eRd = '0;
    for (int k = 0; k < NCH; k++) begin
      eOe[k]  = chanIsOut(k);
      eOut[k] = cfgPol[k] ? mStored[k] : !mStored[k];
      if (busAddr == LVL) eRd[k] = cfgPol[k] ? padHist[0][k] : !padHist[0][k];
    end
    vectors += 3;
    if (padOut !== eOut) begin
      misses++;
      $display("FAIL %s padOut actual %h expected %h", tag, padOut, eOut);
    end
    if (padOe !== eOe) begin
      misses++;
      $display("FAIL %s padOe actual %h expected %h", tag, padOe, eOe);
    end
    if (busRdData !== eRd) begin
      misses++;
      $display("FAIL %s busRdData actual %h expected %h", tag, busRdData, eRd);
    end
  endtask

  // Compare after inputs settle, then advance model on the edge
  task automatic step(string tag);
    #1;
    check(tag);
    @(posedge clk);
    if (busWrEn && busAddr == LVL)
      for (int k = 0; k < NCH; k++)
        if (chanIsOut(k)) mStored[k] = busWrData[k];
    padHist.push_back(padIn);
    void'(padHist.pop_front());
    @(negedge clk);
  endtask

  task automatic drive(logic [15:0] a, logic we, logic [15:0] d);
    busAddr = a;
    busWrEn = we;
    busWrData = d;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    #2_000_000;
    misses++;
    $display("FAIL watchdog expired actual running expected finished");
    finishRun();
  end

  initial begin
    for (int k = 0; k < NCH; k++) mStored[k] = 1'b0;
    padHist.push_back('0);
    padHist.push_back('0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2: reset values with both polarities
    drive(LVL, 0, 0);
    step("R2");
    cfgPol = '0;
    step("R2");
    cfgPol = '1;

    // R1: single bit lands on channel 9 only, then channel 1 only
    drive(LVL, 1, 16'h0100);
    step("R1");
    drive(LVL, 0, 0);
    step("R1");
    drive(LVL, 1, 16'h0001);
    step("R1");
    drive(LVL, 0, 0);
    step("R1");

    // R5: mixed polarity on driven pattern
    cfgPol = 9'h0F0;
    drive(LVL, 1, 16'h0155);
    step("R5");
    drive(LVL, 0, 0);
    step("R5");
    cfgPol = 9'h10F;
    step("R5");

    // R3/R4: blocked channels keep value, eligible ones update
    cfgFunc = 36'h0_0000_0300;   // channel 3 in another function
    cfgDir  = 9'h021;            // channels 1 and 6 as inputs
    cfgPol  = '1;
    drive(LVL, 1, 16'h01FF);
    step("R3");
    drive(LVL, 0, 0);
    step("R4");
    cfgFunc = '0;
    cfgDir  = '0;
    step("R4");

    // R8: upper written bits change nothing
    drive(LVL, 1, 16'hFE00);
    step("R8");
    drive(LVL, 0, 0);
    step("R8");

    // R9: foreign address writes and reads
    drive(16'h4008, 1, 16'h01FF);
    step("R9");
    drive(16'h400D, 0, 0);
    step("R9");
    drive(LVL, 0, 0);
    step("R9");

    // R6/R7: input sampling through synchronizer, both polarities
    cfgDir = '1;
    padIn = 9'h1A5;
    step("R7");
    step("R7");
    step("R7");
    cfgPol = 9'h033;
    step("R6");
    padIn = 9'h05A;
    step("R6");
    step("R6");
    step("R6");

    // R10: output channel read shows pad, not stored value
    cfgDir = '0;
    cfgPol = '1;
    drive(LVL, 1, 16'h00FF);
    padIn = 9'h100;
    step("R10");
    drive(LVL, 0, 0);
    step("R10");
    step("R10");
    step("R10");

    // R3: random configuration and traffic
    for (int n = 0; n < 400; n++) begin
      for (int k = 0; k < NCH; k++)
        cfgFunc[4*k +: 4] = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
      cfgDir = 9'($urandom);
      cfgPol = 9'($urandom);
      padIn  = 9'($urandom);
      drive(($urandom % 5 == 0) ? 16'($urandom) : LVL, 1'($urandom), 16'($urandom));
      step("R3");
    end

    finishRun();
  end
endmodule